// File: doc/BRIEF.md
# Audio Clock Ratio Monitor

This block supervises the clocks that feed a multi-rate audio converter. It samples a master clock and a frame (left/right) clock with a faster reference clock and counts master-clock rising edges in each frame-clock period. It classifies that count against five nominal ratios and decides whether the DAC and ADC paths may run. The decision is made in one of three speed modes, or in an automatic mode that derives the speed from the measured ratio.

When either input clock stops, the block enters a power-save state. Power-save drops both valid flags and discards the held ratio. When both clocks run again, the block measures afresh and releases power-save by itself. A ratio that does not fit the active mode, or a selected speed code that is reserved, forces both flags low and sets a sticky error bit. A one-cycle pulse on `err_clr` clears that bit.

Top module: `audio_clk_ratio_mon`

## Requirements
- R1: After reset, `pwr_save`=1, `dac_ok`=0, `adc_ok`=0, `ratio_code`=0 and `ratio_err`=0, and in manual mode `speed_mode` equals `speed_sel`.
- R2: `pwr_save` stays 1 until the master clock has toggled and a frame-clock rising edge has been seen. It is 0 while both clocks run.
- R3: `ratio_code` gives the measured count of master-clock rising edges per frame period: 1 for 128, 2 for 192, 3 for 256, 4 for 384, 5 for 512, each ±2, and 0 for any other count.
- R4: The first frame period after a wake-up is not measured. `ratio_code` takes a new value only when two consecutive measured periods give the same code, and only on a frame edge.
- R5: With `speed_mode`=00 (normal), `dac_ok` and `adc_ok` are 1 for codes 3, 4 and 5.
- R6: With `speed_mode`=01 (double), `dac_ok` is 1 for codes 1, 2 and 3, and `adc_ok` is 1 only for code 3.
- R7: With `speed_mode`=10 (quad), `dac_ok` is 1 only for code 1, and `adc_ok` is always 0.
- R8: Once a ratio has been held, a code that the active mode does not permit, or speed code 11, drives both flags low and sets `ratio_err`. The bit stays set until an `err_clr` pulse in a cycle with no such mismatch.
- R9: With `auto_mode`=1, `speed_sel` is ignored. `speed_mode` is 00 for codes 4 and 5, 01 for codes 2 and 3, and 10 for code 1.
- R10: If the master clock does not toggle for 64 reference cycles, `pwr_save` becomes 1, both flags drop and `ratio_code` returns to 0.
- R11: If more than 1024 master-clock rising edges pass without a frame-clock rising edge, `pwr_save` becomes 1.
- R12: After either stop, the block relocks without any control action once both clocks run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, faster than twice the master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mck_in | input | 1 | Master clock, sampled |
| frm_in | input | 1 | Frame clock, sampled |
| auto_mode | input | 1 | 0 = manual speed select, 1 = speed derived from ratio |
| speed_sel | input | 2 | Manual speed: 00 normal, 01 double, 10 quad, 11 reserved |
| err_clr | input | 1 | Pulse that clears the sticky error |
| ratio_code | output | 3 | Held ratio class (0 none, 1..5 = 128,192,256,384,512) |
| speed_mode | output | 2 | Active speed mode |
| dac_ok | output | 1 | DAC path may run |
| adc_ok | output | 1 | ADC path may run |
| pwr_save | output | 1 | Power-save state |
| ratio_err | output | 1 | Sticky ratio/mode mismatch |

## Verification
The checks assume that the master clock holds each level for at least two reference cycles, so that no toggle is lost in the synchronizer. The stimulus drives every master-clock half period as two reference cycles, and it changes all inputs on the falling reference edge. Edge counts per frame are therefore exact, and ratios such as 257 and 259 land where the ±2 window predicts. The checks also assume that mode and clear inputs change only between clock edges. The bench changes the frame ratio mid-frame on purpose, which produces single odd periods that the two-frame filter must absorb.

// File: rtl/audio_clk_ratio_mon.sv
module audio_clk_ratio_mon #(
  parameter int REF_TMO    = 64,
  parameter int FRM_TMO    = 1024,
  parameter int BASE_RATIO = 128,
  parameter int TOL        = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mck_in,
  input  logic       frm_in,
  input  logic       auto_mode,
  input  logic [1:0] speed_sel,
  input  logic       err_clr,
  output logic [2:0] ratio_code,
  output logic [1:0] speed_mode,
  output logic       dac_ok,
  output logic       adc_ok,
  output logic       pwr_save,
  output logic       ratio_err
);
  localparam int TW = $clog2(REF_TMO + 1);
  localparam int CW = $clog2(FRM_TMO + 2);
  localparam logic [TW-1:0] TMO_V   = TW'(REF_TMO);
  localparam logic [CW-1:0] CNT_SAT = CW'(FRM_TMO + 1);
  localparam int RT1 = BASE_RATIO;
  localparam int RT2 = BASE_RATIO * 3 / 2;
  localparam int RT3 = BASE_RATIO * 2;
  localparam int RT4 = BASE_RATIO * 3;
  localparam int RT5 = BASE_RATIO * 4;

  logic [2:0]    m_sy, f_sy;
  logic [TW-1:0] tcnt;
  logic [CW-1:0] mcnt;
  logic          frm_dead, armed, prev_ok, locked;
  logic [2:0]    prev_cls, cls, auto_spd;
  logic          dac_perm, adc_perm;

  wire mck_rise = m_sy[1] & ~m_sy[2];
  wire mck_tog  = m_sy[1] ^ m_sy[2];
  wire frm_rise = f_sy[1] & ~f_sy[2];
  wire mck_dead = (tcnt == TMO_V);
  wire meas     = frm_rise & armed & ~pwr_save;
  wire mismatch = locked & ~pwr_save & ~dac_perm;

  function automatic logic [2:0] classify(input logic [CW-1:0] n);
    int v;
    v = int'(n);
    if (v >= RT1 - TOL && v <= RT1 + TOL) return 3'd1;
    if (v >= RT2 - TOL && v <= RT2 + TOL) return 3'd2;
    if (v >= RT3 - TOL && v <= RT3 + TOL) return 3'd3;
    if (v >= RT4 - TOL && v <= RT4 + TOL) return 3'd4;
    if (v >= RT5 - TOL && v <= RT5 + TOL) return 3'd5;
    return 3'd0;
  endfunction

  assign cls      = classify(mcnt);
  assign pwr_save = mck_dead | frm_dead;

  always_comb begin
    case (ratio_code)
      3'd1:         auto_spd = 3'd2;
      3'd2, 3'd3:   auto_spd = 3'd1;
      default:      auto_spd = 3'd0;
    endcase
  end

  assign speed_mode = auto_mode ? auto_spd[1:0] : speed_sel;

  always_comb begin
    case (speed_mode)
      2'b00: begin
        dac_perm = ratio_code inside {3'd3, 3'd4, 3'd5};
        adc_perm = dac_perm;
      end
      2'b01: begin
        dac_perm = ratio_code inside {3'd1, 3'd2, 3'd3};
        adc_perm = (ratio_code == 3'd3);
      end
      2'b10: begin
        dac_perm = (ratio_code == 3'd1);
        adc_perm = 1'b0;
      end
      default: begin
        dac_perm = 1'b0;
        adc_perm = 1'b0;
      end
    endcase
  end

  assign dac_ok = locked & ~pwr_save & dac_perm;
  assign adc_ok = locked & ~pwr_save & adc_perm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sy       <= '0;
      f_sy       <= '0;
      tcnt       <= TMO_V;
      mcnt       <= '0;
      frm_dead   <= 1'b1;
      armed      <= 1'b0;
      prev_ok    <= 1'b0;
      prev_cls   <= '0;
      locked     <= 1'b0;
      ratio_code <= '0;
      ratio_err  <= 1'b0;
    end else begin
      m_sy <= {m_sy[1:0], mck_in};
      f_sy <= {f_sy[1:0], frm_in};

      if (mck_tog)       tcnt <= '0;
      else if (!mck_dead) tcnt <= tcnt + 1'b1;

      if (frm_rise)                        mcnt <= CW'(mck_rise);
      else if (mck_rise && mcnt != CNT_SAT) mcnt <= mcnt + 1'b1;

      if (frm_rise)              frm_dead <= 1'b0;
      else if (mcnt == CNT_SAT)  frm_dead <= 1'b1;

      if (mck_dead)      armed <= 1'b0;
      else if (frm_rise) armed <= 1'b1;
      else if (frm_dead) armed <= 1'b0;

      if (pwr_save) begin
        prev_ok    <= 1'b0;
        locked     <= 1'b0;
        ratio_code <= '0;
      end else if (meas) begin
        prev_cls <= cls;
        prev_ok  <= 1'b1;
        if (prev_ok && cls == prev_cls) begin
          ratio_code <= cls;
          locked     <= 1'b1;
        end
      end

      if (mismatch)     ratio_err <= 1'b1;
      else if (err_clr) ratio_err <= 1'b0;
    end
  end
endmodule

module audio_clk_ratio_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_rise,
  input logic       err_clr,
  input logic [2:0] ratio_code,
  input logic [1:0] speed_mode,
  input logic       dac_ok,
  input logic       adc_ok,
  input logic       pwr_save,
  input logic       ratio_err
);
  // R4
  code_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_save && !$past(pwr_save) && ratio_code != $past(ratio_code)) |-> $past(frm_rise));

  // R6
  dbl_adc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_mode == 2'b01 && adc_ok) |-> ratio_code == 3'd3);

  // R7
  quad_adc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    speed_mode == 2'b10 |-> !adc_ok);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ratio_err) && !$past(err_clr)) |-> ratio_err);

  // R8
  err_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_err) |-> !$past(dac_ok) && !$past(adc_ok));
endmodule

bind audio_clk_ratio_mon audio_clk_ratio_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_rise(frm_rise), .err_clr(err_clr),
  .ratio_code(ratio_code), .speed_mode(speed_mode), .dac_ok(dac_ok),
  .adc_ok(adc_ok), .pwr_save(pwr_save), .ratio_err(ratio_err)
);

// File: tb/test_audio_clk_ratio_mon.sv
module test_audio_clk_ratio_mon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mck_in = 1'b0, frm_in = 1'b0, auto_mode = 1'b0, err_clr = 1'b0;
  logic [1:0] speed_sel = 2'b00;
  logic [2:0] ratio_code;
  logic [1:0] speed_mode;
  logic dac_ok, adc_ok, pwr_save, ratio_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0, cmp_on = 0, gen_on = 0, mck_run = 1, frm_run = 1;
  int ratio = 512, mdiv = 0, hcnt = 0;

  always #10 clk = ~clk;

  audio_clk_ratio_mon i_audio_clk_ratio_mon (
    .clk(clk), .rst_n(rst_n), .mck_in(mck_in), .frm_in(frm_in),
    .auto_mode(auto_mode), .speed_sel(speed_sel), .err_clr(err_clr),
    .ratio_code(ratio_code), .speed_mode(speed_mode), .dac_ok(dac_ok),
    .adc_ok(adc_ok), .pwr_save(pwr_save), .ratio_err(ratio_err));

  // clock generator: master half period = 2 reference cycles
  always @(negedge clk) begin
    if (gen_on && mck_run) begin
      mdiv++;
      if (mdiv == 2) begin
        mdiv = 0;
        mck_in = ~mck_in;
        if (mck_in && frm_run) begin
          hcnt++;
          if (hcnt >= (frm_in ? ratio - ratio / 2 : ratio / 2)) begin
            frm_in = ~frm_in;
            hcnt = 0;
          end
        end
      end
    end
  end

  // behavioural reference model
  int hm[3], hf[3];
  int tc, mc, fd, armed, prev_ok, prev_c, code, locked, err;

  function automatic int nearby(int n, int nom);
    return (n >= nom - 2 && n <= nom + 2) ? 1 : 0;
  endfunction
  function automatic int cls_of(int n);
    if (nearby(n, 128) != 0) return 1;
    if (nearby(n, 192) != 0) return 2;
    if (nearby(n, 256) != 0) return 3;
    if (nearby(n, 384) != 0) return 4;
    if (nearby(n, 512) != 0) return 5;
    return 0;
  endfunction
  function automatic int auto_spd(int c);
    if (c == 1) return 2;
    if (c == 2 || c == 3) return 1;
    return 0;
  endfunction
  function automatic int dac_perm(int m, int c);
    if (m == 0) return (c >= 3 && c <= 5) ? 1 : 0;
    if (m == 1) return (c >= 1 && c <= 3) ? 1 : 0;
    if (m == 2) return (c == 1) ? 1 : 0;
    return 0;
  endfunction
  function automatic int adc_perm(int m, int c);
    if (m == 0) return (c >= 3 && c <= 5) ? 1 : 0;
    if (m == 1) return (c == 3) ? 1 : 0;
    return 0;
  endfunction
  function automatic int mdl_mode();
    return auto_mode ? auto_spd(code) : int'(speed_sel);
  endfunction
  function automatic int mdl_save();
    return (tc == 64 || fd != 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin hm[i] = 0; hf[i] = 0; end
      tc = 64; mc = 0; fd = 1; armed = 0; prev_ok = 0; prev_c = 0;
      code = 0; locked = 0; err = 0;
    end else begin
      int mrise, mtog, frise, mdead, save, mism, meas, c, ntc, nmc, nfd, narm;
      mrise = (hm[1] == 1 && hm[2] == 0) ? 1 : 0;
      mtog  = (hm[1] != hm[2]) ? 1 : 0;
      frise = (hf[1] == 1 && hf[2] == 0) ? 1 : 0;
      mdead = (tc == 64) ? 1 : 0;
      save  = mdl_save();
      mism  = (locked != 0 && save == 0 && dac_perm(mdl_mode(), code) == 0) ? 1 : 0;
      meas  = (frise != 0 && armed != 0 && save == 0) ? 1 : 0;
      c     = cls_of(mc);
      ntc = mtog ? 0 : (mdead ? 64 : tc + 1);
      nmc = frise ? mrise : ((mrise != 0 && mc != 1025) ? mc + 1 : mc);
      nfd = frise ? 0 : ((mc == 1025) ? 1 : fd);
      narm = mdead ? 0 : (frise ? 1 : (fd ? 0 : armed));
      if (save != 0) begin
        prev_ok = 0; locked = 0; code = 0;
      end else if (meas != 0) begin
        if (prev_ok != 0 && c == prev_c) begin code = c; locked = 1; end
        prev_c = c; prev_ok = 1;
      end
      if (mism != 0) err = 1;
      else if (err_clr) err = 0;
      tc = ntc; mc = nmc; fd = nfd; armed = narm;
      hm[2] = hm[1]; hm[1] = hm[0]; hm[0] = int'(mck_in);
      hf[2] = hf[1]; hf[1] = hf[0]; hf[0] = int'(frm_in);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int s, m, ed, ea;
      #1;
      s = mdl_save();
      m = mdl_mode();
      ed = (locked != 0 && s == 0) ? dac_perm(m, code) : 0;
      ea = (locked != 0 && s == 0) ? adc_perm(m, code) : 0;
      n_chk++;
      if (int'(ratio_code) != code || int'(speed_mode) != m || int'(pwr_save) != s ||
          int'(dac_ok) != ed || int'(adc_ok) != ea || int'(ratio_err) != err) begin
        n_fail++;
        $display("FAIL model R2/R3/R5/R6/R8/R9 t=%0t code %0d/%0d mode %0d/%0d save %0d/%0d dac %0d/%0d adc %0d/%0d err %0d/%0d (act/exp)",
          $time, ratio_code, code, speed_mode, m, pwr_save, s, dac_ok, ed, adc_ok, ea, ratio_err, err);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_frames(int n);
    for (int i = 0; i < n; i++) @(posedge frm_in);
    repeat (10) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic flags(string req, int c, int d, int a);
    chk({req, " ratio_code"}, int'(ratio_code), c);
    chk({req, " dac_ok"}, int'(dac_ok), d);
    chk({req, " adc_ok"}, int'(adc_ok), a);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwr_save", int'(pwr_save), 1);
    flags("R1", 0, 0, 0);
    chk("R1 ratio_err", int'(ratio_err), 0);
    chk("R1 speed_mode", int'(speed_mode), 0);
    repeat (20) @(negedge clk);
    chk("R2 pwr_save without clocks", int'(pwr_save), 1);

    gen_on = 1;
    wait_frames(2);
    chk("R2 pwr_save released", int'(pwr_save), 0);
    chk("R4 no code after one measured period", int'(ratio_code), 0);
    wait_frames(1);
    chk("R4 code after two equal periods", int'(ratio_code), 5);
    wait_frames(1);
    flags("R5 normal 512", 5, 1, 1);

    ratio = 384; wait_frames(4);
    flags("R5 normal 384", 4, 1, 1);
    chk("R8 no error on filtered glitch", int'(ratio_err), 0);
    ratio = 257; wait_frames(4);
    flags("R3 tolerance 257", 3, 1, 1);
    ratio = 259; wait_frames(4);
    flags("R3 out of window 259", 0, 0, 0);
    chk("R8 error set", int'(ratio_err), 1);
    ratio = 256; wait_frames(4);
    flags("R5 normal 256", 3, 1, 1);
    chk("R8 sticky", int'(ratio_err), 1);
    pulse_clr();
    chk("R8 cleared", int'(ratio_err), 0);

    speed_sel = 2'b01; repeat (2) @(negedge clk);
    flags("R6 double 256", 3, 1, 1);
    ratio = 192; wait_frames(4);
    flags("R6 double 192", 2, 1, 0);
    ratio = 128; wait_frames(4);
    flags("R6 double 128", 1, 1, 0);
    speed_sel = 2'b10; repeat (2) @(negedge clk);
    flags("R7 quad 128", 1, 1, 0);
    speed_sel = 2'b11; repeat (2) @(negedge clk);
    flags("R8 reserved speed", 1, 0, 0);
    chk("R8 error on reserved speed", int'(ratio_err), 1);
    pulse_clr();
    chk("R8 clear ignored during mismatch", int'(ratio_err), 1);
    speed_sel = 2'b10; repeat (2) @(negedge clk);
    pulse_clr();
    chk("R8 cleared after mismatch ends", int'(ratio_err), 0);

    auto_mode = 1'b1; speed_sel = 2'b11; repeat (2) @(negedge clk);
    chk("R9 auto 128 speed", int'(speed_mode), 2);
    flags("R9 auto 128", 1, 1, 0);
    ratio = 512; wait_frames(4);
    chk("R9 auto 512 speed", int'(speed_mode), 0);
    flags("R9 auto 512", 5, 1, 1);
    ratio = 192; wait_frames(4);
    chk("R9 auto 192 speed", int'(speed_mode), 1);
    flags("R9 auto 192", 2, 1, 0);
    chk("R9 no error in auto", int'(ratio_err), 0);

    auto_mode = 1'b0; speed_sel = 2'b00; ratio = 256; wait_frames(4);
    pulse_clr();
    flags("R5 normal 256 again", 3, 1, 1);

    mck_run = 0; repeat (100) @(negedge clk);
    chk("R10 pwr_save on master stop", int'(pwr_save), 1);
    flags("R10 master stop", 0, 0, 0);
    mck_run = 1; wait_frames(5);
    chk("R12 wake after master stop", int'(pwr_save), 0);
    flags("R12 relock after master stop", 3, 1, 1);

    frm_run = 0; repeat (1000) @(negedge clk);
    chk("R11 no power-save before limit", int'(pwr_save), 0);
    repeat (5000) @(negedge clk);
    chk("R11 pwr_save on frame stop", int'(pwr_save), 1);
    flags("R11 frame stop", 0, 0, 0);
    frm_run = 1; wait_frames(5);
    chk("R12 wake after frame stop", int'(pwr_save), 0);
    flags("R12 relock after frame stop", 3, 1, 1);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule